// File: doc/BRIEF.md
# Power Failure Status and Reboot Policy

This block sits in the always-on (resume) power domain. It records two kinds of supply trouble in an 8-bit status byte: a drop of the platform power-good signal while the machine is running or in light sleep, and a drop of the processor regulator's power-good signal. Software reads the byte and clears each flag by writing a one to its position.

The block also decides whether the machine restarts when platform power-good comes back. A dropout of platform power-good during which the resume-well reset stays deasserted counts as a brown-out of main power only, and a restart is always requested. If the resume-well reset also asserts before power-good returns, the event counts as a full power loss, and a restart is requested only when the after-loss policy input allows it. Regulator dropouts that happen while a voltage/frequency transition is signalled are not recorded.

All power-good and reset inputs are asynchronous and are synchronized inside the block. The sleep state, the policy bit and the register write port are synchronous to the block clock. The block has no streaming data path, so every pin is a plain level or a pulse with no handshake.

Top module: `pwr_fail_status`

## Requirements
- R1: After block reset, `rd_data` is 0x00 and `reboot_req` is low.
- R2: Bits 7:2 of `rd_data` always read 0, and writing ones to them has no effect.
- R3: A falling edge of `cpu_vr_pwrgd` while `vtrans_active` is low sets bit 1 of the status. The bit is visible by the third rising clock edge after the input falls.
- R4: A falling edge of `cpu_vr_pwrgd` while `vtrans_active` is high leaves bit 1 unchanged.
- R5: A falling edge of `plat_pwrgd` sets bit 0 when `sleep_st` is 2'b00 (running) or 2'b01 (light sleep). It leaves bit 0 unchanged when `sleep_st` is 2'b10 (deeper sleep).
- R6: A write with `wr_en` high clears each flag whose `wr_data` bit is 1 and leaves each flag whose `wr_data` bit is 0 unchanged.
- R7: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R8: While `sleep_st` is 2'b11 (mechanical off), bit 0 is held clear and bit 1 is unaffected.
- R9: When `plat_pwrgd` drops and returns while `rsm_rst_n` stays high, a restart is requested whatever the value of `after_loss_off`.
- R10: When `rsm_rst_n` goes low while `plat_pwrgd` is low, the return of `plat_pwrgd` requests a restart only if `after_loss_off` is 0. A value of 1 means the machine stays off.
- R11: A restart request is a pulse of exactly one clock cycle on `reboot_req`, issued on the third rising clock edge after `plat_pwrgd` rises. Full-loss history is discarded after each decision.
- R12: A signal held low sets its flag only once. If software clears the flag while the signal is still low, the flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| plat_pwrgd | input | 1 | Platform power-good, asynchronous |
| cpu_vr_pwrgd | input | 1 | Processor regulator power-good, asynchronous |
| vtrans_active | input | 1 | Voltage/frequency transition in progress, asynchronous |
| rsm_rst_n | input | 1 | Resume-well reset, active low, asynchronous |
| sleep_st | input | 2 | 00 running, 01 light sleep, 10 deeper sleep, 11 mechanical off |
| after_loss_off | input | 1 | 1 = stay off after a full power loss |
| wr_en | input | 1 | Write strobe for the status byte |
| wr_data | input | 8 | Write data, a one clears the matching flag |
| rd_data | output | 8 | Status byte: bit 1 regulator failure, bit 0 power-good failure |
| reboot_req | output | 1 | One-cycle restart request |

## Verification
Regulator drops are applied both with and without a concurrent transition, which shows whether masking works. Platform drops are applied in each of the four sleep states, which separates the states that record a drop, the one that ignores it and the one that forces the flag clear. Each platform drop is paired with both policy values and with the resume reset either quiet or pulsed. The restart pulse count then tells a brown-out from a full loss, and from a full loss under the stay-off policy. Directed cases cover a write-one clear landing on the same edge as a set, a clear while the signal is still held low, and writes to reserved bits.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    SLP_RUN   = 2'b00,
    SLP_LIGHT = 2'b01,
    SLP_DEEP  = 2'b10,
    SLP_MOFF  = 2'b11
  } sleep_e;

  localparam int FLAG_PG   = 0;
  localparam int FLAG_CPU  = 1;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pfs_flags.sv
module pfs_flags
  import pfs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_set,
  input  logic                 pg_set,
  input  logic                 moff,
  input  logic                 wr_en,
  input  logic [NUM_FLAGS-1:0] wr_clr,
  output logic [NUM_FLAGS-1:0] flags
);
  logic [NUM_FLAGS-1:0] set_v;
  logic [NUM_FLAGS-1:0] clr_v;

  always_comb begin
    set_v = '0;
    set_v[FLAG_PG]  = pg_set;
    set_v[FLAG_CPU] = cpu_set;
    clr_v = wr_en ? wr_clr : '0;
    clr_v[FLAG_PG] = clr_v[FLAG_PG] | moff;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        flags[i] <= 1'b0;
      else if (set_v[i]) flags[i] <= 1'b1;
      else if (clr_v[i]) flags[i] <= 1'b0;

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[i] |=> flags[i]);
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_clr[i] && !set_v[i]) |=> !flags[i]);
    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_v[i] && !(wr_en && wr_clr[i]) && !(i == FLAG_PG && moff)) |=> $stable(flags[i]));
  end

  p_moff_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (moff && !pg_set) |=> !flags[FLAG_PG]);
endmodule

// File: rtl/pfs_reboot.sv
module pfs_reboot (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_rise,
  input  logic pg_s,
  input  logic rsm_s,
  input  logic after_loss_off,
  output logic reboot_req
);
  logic full_seen;
  logic full_now;

  assign full_now = full_seen | ~rsm_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                full_seen <= 1'b0;
    else if (pg_rise)          full_seen <= 1'b0;
    else if (!pg_s && !rsm_s)  full_seen <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) reboot_req <= 1'b0;
    else        reboot_req <= pg_rise & ~(after_loss_off & full_now);

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |=> !reboot_req);
  p_hist_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pg_rise |=> !full_seen);
  p_brownout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_rise && rsm_s && !full_seen) |=> reboot_req);
  p_stay_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_rise && after_loss_off && full_seen) |=> !reboot_req);
endmodule

// File: rtl/pwr_fail_status.sv
module pwr_fail_status
  import pfs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STATUS_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                plat_pwrgd,
  input  logic                cpu_vr_pwrgd,
  input  logic                vtrans_active,
  input  logic                rsm_rst_n,
  input  logic [1:0]          sleep_st,
  input  logic                after_loss_off,
  input  logic                wr_en,
  input  logic [STATUS_W-1:0] wr_data,
  output logic [STATUS_W-1:0] rd_data,
  output logic                reboot_req
);
  localparam int          NSYNC   = 4;
  localparam int          RSVD_W  = STATUS_W - NUM_FLAGS;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b1101;

  logic [NSYNC-1:0]     sync_q;
  logic                 pg_s, vr_s, vt_s, rsm_s;
  logic                 pg_q, vr_q;
  logic                 pg_fall, pg_rise, vr_fall;
  logic                 pg_set, cpu_set, moff;
  logic [NUM_FLAGS-1:0] flags;
  sleep_e               slp;
  logic                 unused_wr_bits;

  pfs_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({plat_pwrgd, cpu_vr_pwrgd, vtrans_active, rsm_rst_n}),
    .q     (sync_q)
  );

  assign {pg_s, vr_s, vt_s, rsm_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pg_q <= 1'b1;
      vr_q <= 1'b1;
    end else begin
      pg_q <= pg_s;
      vr_q <= vr_s;
    end

  assign pg_fall = pg_q & ~pg_s;
  assign pg_rise = ~pg_q & pg_s;
  assign vr_fall = vr_q & ~vr_s;

  assign slp     = sleep_e'(sleep_st);
  assign pg_set  = pg_fall && (slp == SLP_RUN || slp == SLP_LIGHT);
  assign cpu_set = vr_fall & ~vt_s;
  assign moff    = (slp == SLP_MOFF);

  pfs_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_set (cpu_set),
    .pg_set  (pg_set),
    .moff    (moff),
    .wr_en   (wr_en),
    .wr_clr  (wr_data[NUM_FLAGS-1:0]),
    .flags   (flags)
  );

  pfs_reboot u_reboot (
    .clk            (clk),
    .rst_n          (rst_n),
    .pg_rise        (pg_rise),
    .pg_s           (pg_s),
    .rsm_s          (rsm_s),
    .after_loss_off (after_loss_off),
    .reboot_req     (reboot_req)
  );

  assign unused_wr_bits = ^wr_data[STATUS_W-1:NUM_FLAGS];
  assign rd_data = {{RSVD_W{1'b0}}, flags};

  p_cpu_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vr_fall && vt_s && !rd_data[FLAG_CPU]) |=> !rd_data[FLAG_CPU]);
  p_pg_deep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_fall && slp == SLP_DEEP && !rd_data[FLAG_PG] && !wr_en) |=> !rd_data[FLAG_PG]);
  p_cpu_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vr_fall && !vt_s) |=> rd_data[FLAG_CPU]);
  p_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!vr_s && !vr_fall && !rd_data[FLAG_CPU]) |=> !rd_data[FLAG_CPU]);
endmodule

// File: tb/pwr_fail_status_test.sv
module pwr_fail_status_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       plat_pwrgd, cpu_vr_pwrgd, vtrans_active, rsm_rst_n;
  logic [1:0] sleep_st;
  logic       after_loss_off, wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       reboot_req;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_st = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_fail_status uut (
    .clk(clk), .rst_n(rst_n), .plat_pwrgd(plat_pwrgd), .cpu_vr_pwrgd(cpu_vr_pwrgd),
    .vtrans_active(vtrans_active), .rsm_rst_n(rsm_rst_n), .sleep_st(sleep_st),
    .after_loss_off(after_loss_off), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .reboot_req(reboot_req)
  );

  function automatic logic [7:0] m_write(logic [7:0] cur, logic [7:0] d);
    return cur & ~d & 8'h03;
  endfunction

  function automatic logic [7:0] m_cpu_drop(logic [7:0] cur, logic vt);
    return vt ? cur : (cur | 8'h02);
  endfunction

  function automatic logic [7:0] m_pg_drop(logic [7:0] cur, logic [1:0] slp);
    if (slp == 2'b11)      return cur & 8'hFE;
    else if (slp[1] == 1'b0) return cur | 8'h01;
    else                   return cur;
  endfunction

  function automatic int m_pulses(logic full, logic pol);
    return (full && pol) ? 0 : 1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(logic [7:0] d, string req);
    wr_en = 1'b1; wr_data = d;
    cyc(1);
    wr_en = 1'b0; wr_data = 8'h00;
    exp_st = m_write(exp_st, d);
    check(req, rd_data, exp_st);
  endtask

  task automatic set_sleep(logic [1:0] s);
    sleep_st = s;
    cyc(2);
    if (s == 2'b11) exp_st = exp_st & 8'hFE;
  endtask

  task automatic cpu_drop(logic vt, string req);
    vtrans_active = vt;
    cyc(1);
    cpu_vr_pwrgd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_st = m_cpu_drop(exp_st, vt);
    check(req, rd_data, exp_st);
    cpu_vr_pwrgd = 1'b1;
    cyc(4);
    vtrans_active = 1'b0;
    cyc(4);
  endtask

  task automatic pg_cycle(logic [1:0] slp, logic full, logic pol, string req_flag, string req_rb);
    int pulses = 0;
    int run = 0;
    int maxrun = 0;
    set_sleep(slp);
    after_loss_off = pol;
    plat_pwrgd = 1'b0;
    cyc(4);
    exp_st = m_pg_drop(exp_st, slp);
    check(req_flag, rd_data, exp_st);
    if (full) begin
      rsm_rst_n = 1'b0; cyc(3);
      rsm_rst_n = 1'b1; cyc(3);
    end
    plat_pwrgd = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (reboot_req) begin
        if (run == 0) pulses++;
        run++;
        if (run > maxrun) maxrun = run;
      end else run = 0;
    end
    check(req_rb, pulses, m_pulses(full, pol));
    if (pulses > 0) check("R11 pulse width", maxrun, 1);
    set_sleep(2'b00);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; plat_pwrgd = 1'b1; cpu_vr_pwrgd = 1'b1; vtrans_active = 1'b0;
    rsm_rst_n = 1'b1; sleep_st = 2'b00; after_loss_off = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check("R1 status", rd_data, 8'h00);
    check("R1 reboot", reboot_req, 1'b0);

    do_write(8'hFC, "R2 reserved write");
    cpu_drop(1'b1, "R4 masked drop");
    cpu_drop(1'b0, "R3 regulator drop");

    // R12: drop held low, clear while still low
    cpu_vr_pwrgd = 1'b0; cyc(4);
    do_write(8'h02, "R6 clear cpu");
    cyc(5);
    check("R12 held low", rd_data, exp_st);
    cpu_vr_pwrgd = 1'b1; cyc(4);

    pg_cycle(2'b00, 1'b0, 1'b1, "R5 running drop", "R9 brownout policy off");
    do_write(8'h02, "R6 clear only cpu");
    pg_cycle(2'b10, 1'b0, 1'b0, "R5 deep sleep drop", "R9 brownout");
    pg_cycle(2'b01, 1'b1, 1'b1, "R5 light drop", "R10 full loss stay off");
    pg_cycle(2'b01, 1'b1, 1'b0, "R5 light drop", "R10 full loss reboot");
    pg_cycle(2'b00, 1'b0, 1'b1, "R5 running drop", "R11 history cleared");
    cpu_drop(1'b0, "R3 regulator drop");
    set_sleep(2'b11);
    check("R8 moff clears pg flag", rd_data, exp_st);
    set_sleep(2'b00);

    // R7: set and clear on the same edge
    do_write(8'h03, "R6 clear both");
    plat_pwrgd = 1'b0;
    cyc(2);
    wr_en = 1'b1; wr_data = 8'h01;
    cyc(1);
    wr_en = 1'b0; wr_data = 8'h00;
    check("R7 set wins", rd_data[0], 1'b1);
    exp_st = exp_st | 8'h01;
    plat_pwrgd = 1'b1; cyc(8);

    for (int it = 0; it < 40; it++) begin
      int op = $urandom_range(0, 2);
      case (op)
        0: cpu_drop(1'($urandom_range(0, 1)), "R3 R4 random regulator");
        1: pg_cycle(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), "R5 R8 random drop", "R9 R10 random reboot");
        default: do_write(8'($urandom_range(0, 255)), "R2 R6 random write");
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule